// File: doc/BRIEF.md
# Dual-Output Aligned PWM Generator

This block generates two pulse-width modulated outputs from a single 16-bit time base. The time base advances once per clock in which the clock-enable tick is high. Each output has its own on-time value and its own start value. The alignment mode is shared by both outputs and decides where the on-time sits within the period: at the start, at the end, around the turnaround of an up/down count, or at a programmable start count.

Software writes the period, mode, on-time and start values through a simple write port into shadow storage. The shadow values have no effect until a load request has been made. The full set is then copied into the working registers on the tick that closes the current period, and the request is cleared at the same time. A synchronous restart input returns the time base to count zero without closing the period. A one-cycle period-end strobe marks every period boundary.

Top module: `dual_pwm_gen`

## Requirements
- R1: After `rst_ni` is asserted, every working and shadow register is zero, `pwm_o` is 0 and no load request is pending. With `tick_i` low, `period_end_o` is 0.
- R2: In the left, right and variable modes, the count steps 0,1,…,P-1 on each tick and then returns to 0, where P is the working period. A period of 0 behaves as a one-count period. `period_end_o` is high during each cycle whose tick moves the count from P-1 back to 0.
- R3: While `tick_i` is low and `sync_rst_i` is low, the count, `pwm_o` and `period_end_o` do not change, and `period_end_o` stays 0.
- R4: In mode 0 (left), output n is high while count < Dn.
- R5: In mode 1 (right), output n is high while count >= P-Dn.
- R6: In mode 2 (center), the count runs 0…P-1, holds at P-1 for one extra tick, and then runs down to 0. The period ends on the tick leaving the down-phase 0, so one period is 2P ticks. Output n is high while count < Dn.
- R7: In mode 3 (variable), output n is high while Sn <= count < Sn+Dn, with the sum taken without wrap.
- R8: An on-time Dn of 0 forces output n low in every mode. A nonzero Dn >= P forces output n high in every mode.
- R9: The write address map is: 0 period, 1 mode (data bits [1:0]), 2 D0, 3 D1, 4 S0, 5 S1. Addresses 6 and 7 are ignored. Writes land in shadow registers and never change the outputs directly. A load request received on any edge is held pending. On the next period-end tick, all shadow values are copied into the working registers together and the request clears. Without a pending request, a period end copies nothing.
- R10: `sync_rst_i` returns the count to 0 in up direction on the next edge, whatever the tick. In that cycle `period_end_o` is 0 and no load takes place.
- R11: Both outputs use the one shared count, and each output applies its own on-time and start values independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time base advance enable |
| sync_rst_i | input | 1 | Synchronous time base restart |
| wr_en_i | input | 1 | Shadow register write strobe |
| wr_addr_i | input | 3 | Shadow register address |
| wr_data_i | input | 16 | Shadow register write data |
| load_req_i | input | 1 | Request copy of shadow set at next period end |
| pwm_o | output | 2 | The two modulated outputs |
| period_end_o | output | 1 | High in the cycle whose tick ends a period |

## Verification
The count is the only register between the inputs and `pwm_o`, so an output change caused by a tick is visible right after that clock edge. The bench drives inputs and samples outputs on the falling edge, one edge after every stimulus. `period_end_o` is combinational from the tick and the count, so the bench checks it in the same half-cycle that the tick is driven. A load request becomes pending one edge after it is driven, and the new values show on the outputs right after the period-end edge that copies them. The bench model applies each effect on the edge where it takes hold and compares at the following falling edge.

// File: rtl/dual_pwm_pkg.sv
package dual_pwm_pkg;
  localparam int CNT_W  = 16;
  localparam int N_OUT  = 2;
  localparam int ADDR_W = 3;
  localparam int DATA_W = CNT_W;

  localparam int A_PERIOD = 0;
  localparam int A_MODE   = 1;
  localparam int A_DUTY0  = 2;
  localparam int A_START0 = A_DUTY0 + N_OUT;

  typedef enum logic [1:0] {
    ALN_LEFT   = 2'd0,
    ALN_RIGHT  = 2'd1,
    ALN_CENTER = 2'd2,
    ALN_VAR    = 2'd3
  } align_e;

  typedef struct packed {
    logic [CNT_W-1:0]            period;
    align_e                      mode;
    logic [N_OUT-1:0][CNT_W-1:0] duty;
    logic [N_OUT-1:0][CNT_W-1:0] start;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import dual_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sync_rst_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_down_o,
  output logic [CNT_W-1:0] pmax_o,
  output logic             pe_o
);
  logic at_end;

  assign pmax_o = (period_i == '0) ? '0 : period_i - 1'b1;
  assign at_end = center_i ? (dir_down_o && cnt_o == '0) : (cnt_o == pmax_o);
  assign pe_o   = tick_i & ~sync_rst_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o      <= '0;
      dir_down_o <= 1'b0;
    end else if (sync_rst_i) begin
      cnt_o      <= '0;
      dir_down_o <= 1'b0;
    end else if (tick_i) begin
      if (!center_i) begin
        dir_down_o <= 1'b0;
        cnt_o      <= at_end ? '0 : cnt_o + 1'b1;
      end else if (!dir_down_o) begin
        // top of the up phase: hold one tick, then turn
        if (cnt_o >= pmax_o) dir_down_o <= 1'b1;
        else                 cnt_o      <= cnt_o + 1'b1;
      end else begin
        if (cnt_o == '0) dir_down_o <= 1'b0;
        else             cnt_o      <= cnt_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp
  import dual_pwm_pkg::*;
(
  input  align_e           mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] start_i,
  output logic             pwm_o
);
  logic [CNT_W:0] stop;

  assign stop = {1'b0, start_i} + {1'b0, duty_i};

  always_comb begin
    if (duty_i == '0)             pwm_o = 1'b0;
    else if (duty_i >= period_i)  pwm_o = 1'b1;
    else begin
      case (mode_i)
        ALN_LEFT:   pwm_o = cnt_i < duty_i;
        ALN_RIGHT:  pwm_o = cnt_i >= (period_i - duty_i);
        ALN_CENTER: pwm_o = cnt_i < duty_i;
        ALN_VAR:    pwm_o = (cnt_i >= start_i) && ({1'b0, cnt_i} < stop);
        default:    pwm_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import dual_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_req_i,
  input  logic              pe_i,
  output pwm_cfg_t          act_o,
  output logic              pend_o
);
  pwm_cfg_t shd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd <= '0;
    end else if (wr_en_i) begin
      if (int'(wr_addr_i) == A_PERIOD) shd.period <= wr_data_i;
      if (int'(wr_addr_i) == A_MODE)   shd.mode   <= align_e'(wr_data_i[1:0]);
      for (int i = 0; i < N_OUT; i++) begin
        if (int'(wr_addr_i) == A_DUTY0 + i)  shd.duty[i]  <= wr_data_i;
        if (int'(wr_addr_i) == A_START0 + i) shd.start[i] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o  <= '0;
      pend_o <= 1'b0;
    end else begin
      if (pe_i && pend_o) act_o <= shd;
      // a new request on the transfer edge stays pending
      pend_o <= load_req_i | (pend_o & ~pe_i);
    end
  end
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
  import dual_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sync_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_req_i,
  output logic [N_OUT-1:0]  pwm_o,
  output logic              period_end_o
);
  pwm_cfg_t         act;
  logic             pend;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] pmax;
  logic             dir_down;

  pwm_cfg_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .load_req_i(load_req_i),
    .pe_i      (period_end_o),
    .act_o     (act),
    .pend_o    (pend)
  );

  pwm_timebase u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .sync_rst_i(sync_rst_i),
    .center_i  (act.mode == ALN_CENTER),
    .period_i  (act.period),
    .cnt_o     (cnt),
    .dir_down_o(dir_down),
    .pmax_o    (pmax),
    .pe_o      (period_end_o)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    pwm_chan_cmp u_cmp (
      .mode_i  (act.mode),
      .cnt_i   (cnt),
      .period_i(act.period),
      .duty_i  (act.duty[g]),
      .start_i (act.start[g]),
      .pwm_o   (pwm_o[g])
    );
  end
endmodule

// File: rtl/dual_pwm_gen_chk.sv
module dual_pwm_gen_chk
  import dual_pwm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             sync_rst_i,
  input logic             load_req_i,
  input logic [N_OUT-1:0] pwm_i,
  input logic             pe_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] pmax_i,
  input logic             dir_down_i,
  input logic             pend_i,
  input pwm_cfg_t         act_i
);
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= pmax_i); // R2

  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !sync_rst_i) |=> ($stable(cnt_i) && $stable(pwm_i))); // R3

  AST_DUTY_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i.duty[0] == '0) |-> !pwm_i[0]); // R8

  AST_DUTY_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_i.duty[1] != '0) && (act_i.duty[1] >= act_i.period)) |-> pwm_i[1]); // R8

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pe_i && pend_i) |=> $stable(act_i)); // R9

  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_i && pend_i && !load_req_i) |=> !pend_i); // R9

  AST_SYNC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rst_i |=> (cnt_i == '0 && !dir_down_i)); // R10
endmodule

bind dual_pwm_gen dual_pwm_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .sync_rst_i(sync_rst_i),
  .load_req_i(load_req_i),
  .pwm_i     (pwm_o),
  .pe_i      (period_end_o),
  .cnt_i     (cnt),
  .pmax_i    (pmax),
  .dir_down_i(dir_down),
  .pend_i    (pend),
  .act_i     (act)
);

// File: tb/dual_pwm_gen_test.sv
`timescale 1ns/1ps
module dual_pwm_gen_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        sync_rst_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        load_req_i = 1'b0;
  logic [1:0]  pwm_o;
  logic        period_end_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  dual_pwm_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .sync_rst_i(sync_rst_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .load_req_i(load_req_i), .pwm_o(pwm_o), .period_end_o(period_end_o)
  );

  // bench model state, kept from the requirements
  int unsigned a_per = 0, a_mode = 0, s_per = 0, s_mode = 0;
  int unsigned a_duty[2] = '{0, 0}, a_start[2] = '{0, 0};
  int unsigned s_duty[2] = '{0, 0}, s_start[2] = '{0, 0};
  bit          m_pend = 1'b0;
  int unsigned pos = 0;
  string       ph = "R11";
  string       mtag[4] = '{"R4", "R5", "R6", "R7"};

  function automatic int unsigned len_f();
    int unsigned p = (a_per == 0) ? 1 : a_per;
    return (a_mode == 2) ? 2 * p : p;
  endfunction

  function automatic int unsigned cnt_f();
    int unsigned p = (a_per == 0) ? 1 : a_per;
    if (a_mode != 2) return pos;
    return (pos < p) ? pos : 2 * p - 1 - pos;
  endfunction

  function automatic bit exp_out(int ch);
    int unsigned c = cnt_f();
    int unsigned d = a_duty[ch];
    if (d == 0) return 1'b0;
    if (d >= a_per) return 1'b1;
    case (a_mode)
      0: return c < d;
      1: return c >= a_per - d;
      2: return c < d;
      default: return (c >= a_start[ch]) && (c < a_start[ch] + d);
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    if (sync_rst_i) pos = 0;
    else if (tick_i) begin
      if (pos == len_f() - 1) begin
        pos = 0;
        if (m_pend) begin
          a_per = s_per; a_mode = s_mode; a_duty = s_duty; a_start = s_start;
          m_pend = 1'b0;
        end
      end else pos++;
    end
    if (load_req_i) m_pend = 1'b1;
    if (wr_en_i) begin
      case (wr_addr_i)
        3'd0: s_per = wr_data_i;
        3'd1: s_mode = wr_data_i[1:0];
        3'd2: s_duty[0] = wr_data_i;
        3'd3: s_duty[1] = wr_data_i;
        3'd4: s_start[0] = wr_data_i;
        3'd5: s_start[1] = wr_data_i;
        default: ;
      endcase
    end
    @(negedge clk);
    for (int ch = 0; ch < 2; ch++) begin
      bit e = exp_out(ch);
      string t = (a_duty[ch] == 0 || a_duty[ch] >= a_per) ? "R8" : mtag[a_mode];
      check(pwm_o[ch] == e, $sformatf("%s %s out%0d", ph, t, ch), pwm_o[ch], e);
    end
    begin
      bit ep = tick_i && !sync_rst_i && (pos == len_f() - 1);
      check(period_end_o == ep, $sformatf("%s R2 period_end", ph), period_end_o, ep);
    end
  endtask

  task automatic run(int n);
    repeat (n) cycle();
  endtask

  task automatic wr(int a, int d);
    wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = 16'(d);
    cycle();
    wr_en_i = 1'b0;
  endtask

  task automatic setup(int mode, int p, int d0, int d1, int s0, int s1);
    tick_i = 1'b0;
    wr(0, p); wr(1, mode); wr(2, d0); wr(3, d1); wr(4, s0); wr(5, s1);
    load_req_i = 1'b1;
    cycle();
    load_req_i = 1'b0;
    tick_i = 1'b1;
  endtask

  task automatic restart();
    sync_rst_i = 1'b1;
    cycle();
    sync_rst_i = 1'b0;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL R2: watchdog expired, actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pwm_o == 2'b00, "R1 pwm in reset", pwm_o, 0);
    check(period_end_o == 1'b0, "R1 period_end in reset", period_end_o, 0);
    rst_ni = 1'b1;
    ph = "R1";
    run(3);

    // R4 with R11: left, two different on-times
    ph = "R4";
    setup(0, 10, 3, 7, 0, 0);
    restart();
    run(25);

    // R3: frozen while tick low
    ph = "R3";
    tick_i = 1'b0;
    run(6);
    tick_i = 1'b1;

    // R9: write without request is ignored, address 6 ignored
    ph = "R9";
    tick_i = 1'b0;
    wr(2, 8); wr(6, 16'hffff);
    tick_i = 1'b1;
    run(22);
    tick_i = 1'b0;
    load_req_i = 1'b1;
    cycle();
    load_req_i = 1'b0;
    tick_i = 1'b1;
    run(24);

    // R5, R6, R7, R8 directed
    ph = "R5";  setup(1, 12, 5, 12, 0, 0);  run(30);
    ph = "R6";  setup(2, 9, 4, 0, 0, 0);    run(40);
    ph = "R7";  setup(3, 16, 4, 6, 3, 12);  run(40);
    ph = "R8";  setup(0, 8, 0, 20, 0, 0);   run(20);
    ph = "R6";  setup(2, 1, 1, 0, 0, 0);    run(8);

    // R10: restart at the final count with a load pending
    ph = "R10";
    setup(0, 6, 2, 4, 0, 0);
    run(8);
    tick_i = 1'b0;
    wr(2, 5);
    load_req_i = 1'b1;
    cycle();
    load_req_i = 1'b0;
    tick_i = 1'b1;
    while (pos != len_f() - 1) cycle();
    restart();
    run(14);

    // random configurations
    ph = "R11";
    for (int it = 0; it < 24; it++) begin
      int p   = 2 + int'($urandom % 29);
      int md  = int'($urandom % 4);
      int d0  = int'($urandom % (p + 2));
      int d1  = int'($urandom % (p + 2));
      int s0  = int'($urandom % (p + 1));
      int s1  = int'($urandom % (p + 1));
      int old = int'(len_f());
      setup(md, p, d0, d1, s0, s1);
      run(old + 1);
      if (it % 3 == 0) restart();
      run(2 * int'(len_f()) + 3);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule